// File: doc/BRIEF.md
# Supervisory Reset and Interrupt Generator

This block turns the status of a small power supervisor into its two output pins: a system reset and an interrupt, both active-low and open-drain. Each of four monitored supply channels reports an under-voltage flag and an over-voltage flag. Those flags come from comparators that are always running. Two independent per-channel enable masks decide which flags may pull the reset pin and which may pull the interrupt pin. A manual reset input, a watchdog expiry event and a longdog expiry event join the same two paths.

All inputs are synchronous flags. They are sampled by one register stage. The reset output is stretched: after every reset cause has gone away, reset stays asserted for a selectable number of prescaled ticks. The interrupt output has no stretching. Each pin is modelled as a drive enable, where 1 means the pin is pulled low.

Top module: `supervisor_rst_irq`

## Requirements
- R1: While the synchronous reset `rst` is high, `rst_drive_o` reads 1 and `irq_drive_o` reads 0 from the first clock edge on.
- R2: A low level on `mrst_n_i` sampled at a clock edge makes `rst_drive_o` 1 in the next cycle, whatever the enable masks hold.
- R3: Reset stays asserted for the whole time `mrst_n_i` is low, plus exactly T = max(`tmo_sel_i`,1) × `PRESC_DIV` cycles. Those cycles are counted from the first edge that samples no cause, and `rst_drive_o` is 0 after T cycles.
- R4: Bit i of `rst_en_uv_i` or `rst_en_ov_i` lets channel i's under- or over-voltage flag assert reset with one cycle of latency. With the bit clear, that flag leaves `rst_drive_o` at 0.
- R5: A `ldog_expire_i` pulse asserts reset in the next cycle, followed by the timeout of R3.
- R6: Bit i of `irq_en_uv_i` or `irq_en_ov_i` lets channel i's flag drive `irq_drive_o` one cycle later. This mask is independent of the reset mask. The interrupt drops one cycle after its last cause clears, with no stretching.
- R7: A `wdog_expire_i` pulse asserts `irq_drive_o` for exactly one cycle, one cycle later, and does not assert reset.
- R8: A reset cause that arrives while the timeout is counting restarts the full timeout after that cause clears.
- R9: `tmo_sel_i` = 0 gives a timeout of one tick (`PRESC_DIV` cycles).
- R10: When `rst` is released with no cause present, reset stays asserted for T cycles, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_uv_i | input | NUM_CH | Under-voltage flag, one per channel |
| mon_ov_i | input | NUM_CH | Over-voltage flag, one per channel |
| rst_en_uv_i | input | NUM_CH | Reset enable for the under-voltage flags |
| rst_en_ov_i | input | NUM_CH | Reset enable for the over-voltage flags |
| irq_en_uv_i | input | NUM_CH | Interrupt enable for the under-voltage flags |
| irq_en_ov_i | input | NUM_CH | Interrupt enable for the over-voltage flags |
| mrst_n_i | input | 1 | Manual reset, active low |
| wdog_expire_i | input | 1 | Watchdog timeout event |
| ldog_expire_i | input | 1 | Longdog timeout event |
| tmo_sel_i | input | SEL_W | Reset timeout in prescaled ticks (0 means 1) |
| rst_drive_o | output | 1 | 1 = reset pin pulled low |
| irq_drive_o | output | 1 | 1 = interrupt pin pulled low |

## Verification
Internal state in this block is limited to the sampled cause register, the hold state with its tick counter, and the prescaler phase. A wrong value in any of them shows up as a reset pulse of the wrong length. It can also show up as a spurious or missing reset or interrupt edge, exactly one cycle after the stimulus or at the end of the timeout. The bench compares both pins against a behavioural model on every cycle, so a wrong count is caught in the first cycle where the pin differs. It also measures hold lengths for normal, zero and restarted timeouts directly.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Sampled cause pair feeding the two output paths.
    typedef struct packed {
        logic rst_req;
        logic irq_req;
    } sup_req_t;

    // Reset stretcher state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } sup_state_e;

    // Timeout selection in ticks; a zero selection still gives one tick.
    function automatic int unsigned sel_to_ticks(input int unsigned sel);
        return (sel == 0) ? 1 : sel;
    endfunction

endpackage

// File: rtl/sup_cause_combine.sv
module sup_cause_combine
    import sup_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] mon_uv_i,
    input  logic [NUM_CH-1:0] mon_ov_i,
    input  logic [NUM_CH-1:0] rst_en_uv_i,
    input  logic [NUM_CH-1:0] rst_en_ov_i,
    input  logic [NUM_CH-1:0] irq_en_uv_i,
    input  logic [NUM_CH-1:0] irq_en_ov_i,
    input  logic              mrst_n_i,
    input  logic              wdog_expire_i,
    input  logic              ldog_expire_i,
    output sup_req_t          req_q
);

    logic [NUM_CH-1:0] ch_rst;
    logic [NUM_CH-1:0] ch_irq;
    sup_req_t          req_d;

    // Per-channel gating: monitors always run, masks pick the path.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ch_rst[i] = (mon_uv_i[i] & rst_en_uv_i[i]) | (mon_ov_i[i] & rst_en_ov_i[i]);
        assign ch_irq[i] = (mon_uv_i[i] & irq_en_uv_i[i]) | (mon_ov_i[i] & irq_en_ov_i[i]);
    end

    always_comb begin
        req_d.rst_req = ~mrst_n_i | (|ch_rst) | ldog_expire_i;
        req_d.irq_req = wdog_expire_i | (|ch_irq);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q.rst_req <= 1'b1;
            req_q.irq_req <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    // R4: with no reset enable bit set, monitor flags never reach the reset request
    a_r4_mask_gate: assert property (@(posedge clk) disable iff (rst)
        (rst_en_uv_i == '0 && rst_en_ov_i == '0 && mrst_n_i && !ldog_expire_i)
        |=> !req_q.rst_req);

endmodule

// File: rtl/sup_tick_prescaler.sv
module sup_tick_prescaler #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);

    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST) && !clr_i;

    // Counter never leaves its range
    a_r3_pre_range: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q <= LAST));

endmodule

// File: rtl/sup_reset_stretch.sv
module sup_reset_stretch
    import sup_pkg::*;
#(
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cause_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             tick_i,
    output logic             pre_clr_o,
    output logic             drive_o
);

    sup_state_e       state_q;
    logic [SEL_W-1:0] ticks_q;
    logic [SEL_W-1:0] load_val;

    assign load_val = SEL_W'(sel_to_ticks(int'(sel_i)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ticks_q <= '0;
        end else if (cause_i) begin
            // Any live cause (re)loads the full timeout
            state_q <= ST_HOLD;
            ticks_q <= load_val;
        end else if (state_q == ST_HOLD && tick_i) begin
            if (ticks_q == SEL_W'(1)) begin
                state_q <= ST_IDLE;
                ticks_q <= '0;
            end else begin
                ticks_q <= ticks_q - 1'b1;
            end
        end
    end

    // Prescaler runs only while holding with no cause, so every hold is phase-aligned
    assign pre_clr_o = cause_i || (state_q == ST_IDLE);
    assign drive_o   = cause_i || (state_q == ST_HOLD);

    // R3: reset stays asserted in the cycle after its cause clears
    a_r3_hold_after_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(cause_i) |-> drive_o);

    // R9: a live cause always leaves a nonzero tick count behind
    a_r9_load_nonzero: assert property (@(posedge clk) disable iff (rst)
        cause_i |=> (ticks_q != '0));

    // R8: without a cause the count only goes down
    a_r8_count_down: assert property (@(posedge clk) disable iff (rst)
        (!cause_i && state_q == ST_HOLD) |=> (ticks_q <= $past(ticks_q)));

    // R3: hold state and count agree
    a_r3_state_count: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |-> (ticks_q != '0));

endmodule

// File: rtl/supervisor_rst_irq.sv
module supervisor_rst_irq
    import sup_pkg::*;
#(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned PRESC_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] mon_uv_i,
    input  logic [NUM_CH-1:0] mon_ov_i,
    input  logic [NUM_CH-1:0] rst_en_uv_i,
    input  logic [NUM_CH-1:0] rst_en_ov_i,
    input  logic [NUM_CH-1:0] irq_en_uv_i,
    input  logic [NUM_CH-1:0] irq_en_ov_i,
    input  logic              mrst_n_i,
    input  logic              wdog_expire_i,
    input  logic              ldog_expire_i,
    input  logic [SEL_W-1:0]  tmo_sel_i,
    output logic              rst_drive_o,
    output logic              irq_drive_o
);

    sup_req_t req_q;
    logic     tick;
    logic     pre_clr;

    sup_cause_combine #(.NUM_CH(NUM_CH)) u_comb (
        .clk           (clk),
        .rst           (rst),
        .mon_uv_i      (mon_uv_i),
        .mon_ov_i      (mon_ov_i),
        .rst_en_uv_i   (rst_en_uv_i),
        .rst_en_ov_i   (rst_en_ov_i),
        .irq_en_uv_i   (irq_en_uv_i),
        .irq_en_ov_i   (irq_en_ov_i),
        .mrst_n_i      (mrst_n_i),
        .wdog_expire_i (wdog_expire_i),
        .ldog_expire_i (ldog_expire_i),
        .req_q         (req_q)
    );

    sup_tick_prescaler #(.DIV(PRESC_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (pre_clr),
        .tick_o (tick)
    );

    sup_reset_stretch #(.SEL_W(SEL_W)) u_stretch (
        .clk       (clk),
        .rst       (rst),
        .cause_i   (req_q.rst_req),
        .sel_i     (tmo_sel_i),
        .tick_i    (tick),
        .pre_clr_o (pre_clr),
        .drive_o   (rst_drive_o)
    );

    assign irq_drive_o = req_q.irq_req;

    // R2: manual reset asserts reset one cycle later regardless of masks
    a_r2_manual: assert property (@(posedge clk) disable iff (rst)
        !mrst_n_i |=> rst_drive_o);

    // R5: longdog expiry asserts reset
    a_r5_ldog: assert property (@(posedge clk) disable iff (rst)
        ldog_expire_i |=> rst_drive_o);

    // R7: watchdog expiry asserts the interrupt
    a_r7_wdog: assert property (@(posedge clk) disable iff (rst)
        wdog_expire_i |=> irq_drive_o);

    // R6: no enabled interrupt cause means no interrupt one cycle later
    a_r6_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (!wdog_expire_i && (mon_uv_i & irq_en_uv_i) == '0 && (mon_ov_i & irq_en_ov_i) == '0)
        |=> !irq_drive_o);

endmodule

// File: tb/supervisor_rst_irq_tb_top.sv
`timescale 1ns/1ps
module supervisor_rst_irq_tb_top;

    localparam int NCH = 4;
    localparam int SW  = 4;
    localparam int DIV = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] uv = '0, ov = '0, reu = '0, reo = '0, ieu = '0, ieo = '0;
    logic           mr_n = 1'b1, wd = 1'b0, ld = 1'b0;
    logic [SW-1:0]  sel = SW'(3);
    logic           rst_drv, irq_drv;

    always #2.5 clk = ~clk;

    supervisor_rst_irq #(.NUM_CH(NCH), .SEL_W(SW), .PRESC_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .mon_uv_i(uv), .mon_ov_i(ov),
        .rst_en_uv_i(reu), .rst_en_ov_i(reo), .irq_en_uv_i(ieu), .irq_en_ov_i(ieo),
        .mrst_n_i(mr_n), .wdog_expire_i(wd), .ldog_expire_i(ld), .tmo_sel_i(sel),
        .rst_drive_o(rst_drv), .irq_drive_o(irq_drv)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    finished = 0;

    // Behavioural reference: cause flag, remaining hold cycles, interrupt flag
    bit m_cause = 1, m_irq = 0;
    int m_rem = 0;

    function automatic int hold_len(input int s);
        return ((s == 0) ? 1 : s) * DIV;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cause = 1; m_rem = 0; m_irq = 0;
        end else begin
            if (m_cause) m_rem = hold_len(int'(sel));
            else if (m_rem > 0) m_rem = m_rem - 1;
            m_cause = !mr_n || ((uv & reu) != 0) || ((ov & reo) != 0) || ld;
            m_irq   = wd || ((uv & ieu) != 0) || ((ov & ieo) != 0);
        end
        started = 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(cur_req, "rst_drive_o vs model", int'(rst_drv), int'(m_cause || m_rem > 0));
            chk(cur_req, "irq_drive_o vs model", int'(irq_drv), int'(m_irq));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count negedges with reset driven; called right after the last cause is removed
    task automatic measure(input string req, input int exp);
        int cnt = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (rst_drv) cnt++;
            else break;
        end
        chk(req, "hold length", cnt, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        cyc(3);
        chk("R1", "rst_drive_o in reset", int'(rst_drv), 1);
        chk("R1", "irq_drive_o in reset", int'(irq_drv), 0);
        // R10: power-on hold after reset release
        cur_req = "R10";
        rst = 0;
        measure("R10", hold_len(3));
        cyc(2);

        // R2 / R3: manual reset with all masks clear
        cur_req = "R2";
        mr_n = 0;
        cyc(1);
        chk("R2", "manual reset asserted", int'(rst_drv), 1);
        cyc(6);
        cur_req = "R3";
        mr_n = 1;
        measure("R3", hold_len(3));
        cyc(2);
        sel = SW'(5);
        mr_n = 0; cyc(2); mr_n = 1;
        measure("R3", hold_len(5));
        cyc(2);

        // R9: zero selection
        cur_req = "R9";
        sel = '0;
        mr_n = 0; cyc(3); mr_n = 1;
        measure("R9", hold_len(0));
        cyc(2);
        sel = SW'(2);

        // R4: masked flags do not reset, enabled flags do
        cur_req = "R4";
        uv = 4'b0100; ov = 4'b0001; reu = 4'b1011; reo = 4'b1110;
        cyc(4);
        chk("R4", "masked uv/ov keep reset off", int'(rst_drv), 0);
        reu = 4'b0100;
        cyc(1);
        chk("R4", "enabled uv ch2 resets", int'(rst_drv), 1);
        uv = '0;
        measure("R4", hold_len(2));
        reo = 4'b0001;
        cyc(1);
        chk("R4", "enabled ov ch0 resets", int'(rst_drv), 1);
        ov = '0; reu = '0; reo = '0;
        measure("R4", hold_len(2));
        cyc(2);

        // R5: longdog pulse
        cur_req = "R5";
        ld = 1; cyc(1); ld = 0;
        chk("R5", "longdog resets", int'(rst_drv), 1);
        measure("R5", hold_len(2));
        cyc(2);

        // R6: interrupt mask independent of reset mask, no stretch
        cur_req = "R6";
        uv = 4'b0010; ov = 4'b1000; ieu = 4'b0010; ieo = 4'b0000; reu = 4'b1101; reo = 4'b0111;
        cyc(1);
        chk("R6", "irq from enabled uv ch1", int'(irq_drv), 1);
        chk("R6", "no reset from irq-only flag", int'(rst_drv), 0);
        uv = '0;
        cyc(1);
        chk("R6", "irq drops without stretch", int'(irq_drv), 0);
        ieo = 4'b1000;
        cyc(1);
        chk("R6", "irq from enabled ov ch3", int'(irq_drv), 1);
        ov = '0; ieu = '0; ieo = '0; reu = '0; reo = '0;
        cyc(2);

        // R7: watchdog pulse
        cur_req = "R7";
        wd = 1; cyc(1); wd = 0;
        chk("R7", "watchdog irq", int'(irq_drv), 1);
        chk("R7", "watchdog no reset", int'(rst_drv), 0);
        cyc(1);
        chk("R7", "watchdog irq one cycle", int'(irq_drv), 0);
        cyc(2);

        // R8: new cause during hold restarts timeout
        cur_req = "R8";
        sel = SW'(4);
        mr_n = 0; cyc(2); mr_n = 1;
        cyc(9);
        chk("R8", "still holding", int'(rst_drv), 1);
        ld = 1; cyc(1); ld = 0;
        measure("R8", hold_len(4));
        cyc(3);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule